// File: doc/BRIEF.md
# Synchronous Transfer Parameter Encoder

This block turns an agreed synchronous transfer period and REQ/ACK offset into the 8-bit value that programs a parallel bus controller's synchronous timing. The period is given in 4 ns units and the bus clock in MHz. The block starts from a truncated divisor estimate and then works out the strobe period that the estimate would actually produce. If that strobe comes out faster than the agreed period, it raises the divisor by one. It then limits the divisor to its field width and packs the offset above it. The same handshake also returns the selection-timeout count for that clock.

A single `start` pulse launches a computation. One shared restoring divider runs twice in sequence, so the result arrives a fixed, bounded number of cycles later. The outputs hold their values until the next result is ready, and `done` pulses once when they change.

Top module: `sync_param_enc`

## Requirements
- R1: When `sync_en` is low or `offset` is zero, `param_out` is 0x02 (asynchronous), regardless of period.
- R2: Otherwise the divisor starts as floor(period × freq / 500) − 2, limited below at 0. `param_out[7:4]` carries the offset and `param_out[3:0]` the final divisor.
- R3: The strobe period is computed as floor(1250 / freq) when the divisor is 0, and as floor((divisor + 2) × 500 / freq) otherwise. If it is below the requested period, the divisor is raised by one.
- R4: A divisor above 15 after the R3 step is clamped to 15.
- R5: `seltmo_out` equals floor(freq / 2) for every completed request.
- R6: A frequency of zero gives `err` = 1, `param_out` = 0x02 and `seltmo_out` = 0. The next completion with a nonzero frequency clears `err`.
- R7: `done` is high for exactly one cycle per accepted request, no more than 34 cycles after the accepting edge. `param_out`, `seltmo_out` and `err` change only together with `done`.
- R8: A `start` that arrives while a computation is in progress is ignored. It yields no extra `done` and does not alter the result.
- R9: After reset, `param_out`, `seltmo_out`, `err` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| period | input | 8 | Agreed transfer period in 4 ns units |
| offset | input | 4 | Agreed synchronous offset |
| sync_en | input | 1 | Target operates in synchronous mode |
| freq_mhz | input | 8 | Bus clock frequency in MHz |
| param_out | output | 8 | Packed offset and divisor, or 0x02 |
| seltmo_out | output | 8 | Selection-timeout count |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | Zero frequency was supplied |

## Verification
The bound checker covers, on every cycle, the properties that depend only on handshake timing. It checks the single-cycle `done`, the latency bound, that outputs move only with `done`, that no request is accepted mid-computation, and that a zero-frequency result is always the asynchronous code. The arithmetic itself can only be shown by the bench's scenarios. These are the truncated estimate, the round-up after the strobe check, the zero-divisor strobe formula and the clamp to 15, each compared against values worked out by hand for chosen period and frequency pairs. The bench also demonstrates that a mid-computation request is dropped and that the error flag clears.

// File: rtl/sync_param_enc.sv
module sync_param_enc #(
  parameter int PW = 8,
  parameter int OW = 4,
  parameter int FW = 8,
  parameter int VW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PW-1:0]     period,
  input  logic [OW-1:0]     offset,
  input  logic              sync_en,
  input  logic [FW-1:0]     freq_mhz,
  output logic [OW+VW-1:0]  param_out,
  output logic [FW-1:0]     seltmo_out,
  output logic              done,
  output logic              err
);
  localparam int NW   = PW + FW;
  localparam int CW   = $clog2(NW);
  localparam int VMAX = (1 << VW) - 1;
  localparam logic [NW-1:0] K_EST  = NW'(500);
  localparam logic [NW-1:0] K_ZERO = NW'(1250);
  localparam logic [NW-1:0] K_STEP = NW'(500);
  localparam logic [OW+VW-1:0] ASYNC = (OW+VW)'(2);

  typedef enum logic [1:0] {S_IDLE, S_EST, S_STRB, S_FIN} st_t;

  st_t st;
  logic [PW-1:0] p_q;
  logic [OW-1:0] o_q;
  logic [FW-1:0] f_q;
  logic          async_q;
  logic [NW:0]   rem;
  logic [NW-1:0] quo, den, v_q;
  logic [CW-1:0] cnt;

  logic          idle, accept, ge, last;
  logic [NW:0]   trial;
  logic [NW-1:0] q_next;
  logic [VW-1:0] v_clamp;

  assign idle    = (st == S_IDLE);
  assign accept  = idle & start;
  assign trial   = {rem[NW-1:0], quo[NW-1]};
  assign ge      = trial >= {1'b0, den};
  assign q_next  = {quo[NW-2:0], ge};
  assign last    = (cnt == CW'(NW-1));
  assign v_clamp = (v_q > NW'(VMAX)) ? VW'(VMAX) : v_q[VW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      p_q <= '0; o_q <= '0; f_q <= '0; async_q <= 1'b0;
      rem <= '0; quo <= '0; den <= '0; v_q <= '0; cnt <= '0;
      param_out <= '0; seltmo_out <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          p_q <= period;
          o_q <= offset;
          f_q <= freq_mhz;
          if (!sync_en || offset == '0 || freq_mhz == '0) begin
            async_q <= 1'b1;
            st <= S_FIN;
          end else begin
            async_q <= 1'b0;
            rem <= '0;
            quo <= NW'(period) * NW'(freq_mhz);
            den <= K_EST;
            cnt <= '0;
            st <= S_EST;
          end
        end
        S_EST, S_STRB: begin
          rem <= ge ? (trial - {1'b0, den}) : trial;
          quo <= q_next;
          cnt <= cnt + CW'(1);
          if (last) begin
            rem <= '0;
            cnt <= '0;
            if (st == S_EST) begin
              v_q <= (q_next < NW'(2)) ? '0 : q_next - NW'(2);
              quo <= (q_next <= NW'(2)) ? K_ZERO : NW'(q_next * K_STEP);
              den <= NW'(f_q);
              st  <= S_STRB;
            end else begin
              v_q <= v_q + NW'(q_next < NW'(p_q));
              st  <= S_FIN;
            end
          end
        end
        S_FIN: begin
          param_out  <= async_q ? ASYNC : {o_q, v_clamp};
          seltmo_out <= f_q >> 1;
          err        <= (f_q == '0);
          done       <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sync_param_enc_chk #(
  parameter int OW = 4,
  parameter int VW = 4,
  parameter int FW = 8,
  parameter int NW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             idle,
  input logic             done,
  input logic             err,
  input logic [OW+VW-1:0] param_out,
  input logic [FW-1:0]    seltmo_out
);
  localparam int LAT_MAX = 2 * NW + 4;
  logic       busy_c;
  logic [7:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      lat <= '0;
    end else if (idle && start) begin
      busy_c <= 1'b1;
      lat <= '0;
    end else if (done) begin
      busy_c <= 1'b0;
    end else if (busy_c && lat != 8'hFF) begin
      lat <= lat + 8'd1;
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_c |-> lat <= 8'(LAT_MAX));
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(param_out) |-> done);
  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |-> (!busy_c || done));
  assert_zero_freq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (param_out == (OW+VW)'(2) && seltmo_out == '0));
endmodule

bind sync_param_enc sync_param_enc_chk #(.OW(OW), .VW(VW), .FW(FW), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .idle(idle), .done(done),
  .err(err), .param_out(param_out), .seltmo_out(seltmo_out)
);

// File: tb/sync_param_enc_tb.sv
module sync_param_enc_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sync_en = 1'b0;
  logic [7:0] period = '0, freq_mhz = '0;
  logic [3:0] offset = '0;
  logic [7:0] param_out, seltmo_out;
  logic done, err;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sync_param_enc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .period(period), .offset(offset),
    .sync_en(sync_en), .freq_mhz(freq_mhz), .param_out(param_out),
    .seltmo_out(seltmo_out), .done(done), .err(err)
  );

  // {sync_en, offset, period, freq, exp_param, exp_seltmo, exp_err}
  localparam int NV = 11;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 4'd15, 8'd25,  8'd50,  8'hF0, 8'd25,  1'b0},
    {1'b1, 4'd8,  8'd25,  8'd40,  8'h80, 8'd20,  1'b0},
    {1'b1, 4'd15, 8'd50,  8'd50,  8'hF3, 8'd25,  1'b0},
    {1'b1, 4'd10, 8'd55,  8'd50,  8'hA4, 8'd25,  1'b0},
    {1'b1, 4'd1,  8'd200, 8'd100, 8'h1F, 8'd50,  1'b0},
    {1'b1, 4'd15, 8'd255, 8'd255, 8'hFF, 8'd127, 1'b0},
    {1'b1, 4'd3,  8'd10,  8'd20,  8'h30, 8'd10,  1'b0},
    {1'b1, 4'd7,  8'd100, 8'd33,  8'h75, 8'd16,  1'b0},
    {1'b0, 4'd15, 8'd50,  8'd50,  8'h02, 8'd25,  1'b0},
    {1'b1, 4'd0,  8'd50,  8'd50,  8'h02, 8'd25,  1'b0},
    {1'b1, 4'd5,  8'd50,  8'd0,   8'h02, 8'd0,   1'b1}
  };

  function automatic string tag(int i);
    case (i)
      3, 7:    return "R3";
      4, 5:    return "R4";
      8, 9:    return "R1";
      10:      return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(logic s, logic [3:0] o, logic [7:0] p, logic [7:0] f, output int n);
    @(negedge clk);
    sync_en = s; offset = o; period = p; freq_mhz = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, dones;
    repeat (3) @(negedge clk);
    chk("R9", "param_out", 32'(param_out), 0);
    chk("R9", "seltmo", 32'(seltmo_out), 0);
    chk("R9", "done", 32'(done), 0);
    chk("R9", "err", 32'(err), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      run(v[37], v[36:33], v[32:25], v[24:17], n);
      chk(tag(i), "param_out", 32'(param_out), 32'(v[16:9]));
      chk("R5", "seltmo", 32'(seltmo_out), 32'(v[8:1]));
      chk(v[0] ? "R6" : tag(i), "err", 32'(err), 32'(v[0]));
      chk("R7", "latency_ok", 32'(n <= 35 && done), 1);
      @(negedge clk);
      chk("R7", "done_low_after", 32'(done), 0);
    end

    // R6: error clears on the next good completion
    run(1'b1, 4'd15, 8'd50, 8'd50, n);
    chk("R6", "err_cleared", 32'(err), 0);

    // R8: a second start during computation is ignored
    @(negedge clk);
    sync_en = 1'b1; offset = 4'd10; period = 8'd55; freq_mhz = 8'd50; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    sync_en = 1'b0; offset = 4'd0; freq_mhz = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    for (int k = 0; k < 60; k++) begin
      if (done) begin
        dones++;
        if (dones == 1) begin
          chk("R8", "param_out", 32'(param_out), 32'h A4);
          chk("R8", "err", 32'(err), 0);
        end
      end
      @(negedge clk);
    end
    chk("R8", "done_count", 32'(dones), 1);
    chk("R7", "output_held", 32'(param_out), 32'hA4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule